// File: doc/BRIEF.md
# GPIO Controller with Level-Match Interrupts

This block manages a bank of general-purpose pins through a small word-addressed register bus. Software selects, bit by bit, whether each pin belongs to the controller or to an alternate peripheral, and whether it is driven or only observed. The controller drives the output value and output enable toward the pad. It brings each incoming pad level through a two-stage synchroniser and hands the synchronised value both to software and to the alternate peripherals.

Each pin also has a programmable compare level. Whenever the synchronised pin value equals that level, a sticky flag for the pin is raised. The flag stays up until software writes a one to it. A per-pin routing mask sends each raised flag either to the non-maskable interrupt output or to the ordinary interrupt output.

Top module: `gpio_lvlirq`

## Requirements
- R1: While reset is asserted, every register reads zero, `pad_oe` is zero and both `irq` and `nmi` are low.
- R2: Word offsets select the registers: 0 function select, 1 direction, 2 pin data, 3 compare level, 4 flags, 5 NMI routing. Offsets 6 and 7 read zero, and writes to them change nothing.
- R3: With a function bit of 0, `pad_out` carries the data register bit and `pad_oe` carries the direction bit (1 = drive). With a function bit of 1, both come from `alt_out` and `alt_oe`.
- R4: Offset 2 reads, and `alt_in` carries, `pad_in` delayed through two flops. A pad change becomes visible after the second rising edge.
- R5: A flag bit is set on the clock edge that follows a cycle in which the synchronised pin bit equals the level bit.
- R6: A set flag bit stays set while no clear is written for it, even after the pin no longer matches.
- R7: Writing offset 4 clears each flag bit written as 1. Bits written as 0 keep their value.
- R8: If a flag bit is cleared in the same cycle that its match holds, the bit stays set.
- R9: `nmi` is high when any flag bit with a routing bit of 1 is set. `irq` is high when any flag bit with a routing bit of 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Value driven toward the pads |
| pad_oe | output | 32 | Output enable toward the pads |
| alt_out | input | 32 | Alternate peripheral output values |
| alt_oe | input | 32 | Alternate peripheral output enables |
| alt_in | output | 32 | Synchronised pad levels for the alternate peripherals |
| irq | output | 1 | Maskable interrupt |
| nmi | output | 1 | Non-maskable interrupt |

## Verification
The hardest case to reach is a clear written to a flag in exactly the cycle where that pin still matches its level, because the match depends on a pad value that entered two flops earlier. A directed sequence holds the pads steady against the level, so the match is certain, and then writes an all-ones clear. Long random runs add many more such collisions, since random pad values keep about half the pins matching while the random writes hit the flag offset.

// File: rtl/gpio_lvlirq_pkg.sv
package gpio_lvlirq_pkg;

  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_FUNC  = 3'd0,
    REG_DIR   = 3'd1,
    REG_DATA  = 3'd2,
    REG_LEVEL = 3'd3,
    REG_FLAG  = 3'd4,
    REG_ROUTE = 3'd5
  } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] use_alt,
  input  logic [WIDTH-1:0] sw_out,
  input  logic [WIDTH-1:0] sw_oe,
  input  logic [WIDTH-1:0] alt_out,
  input  logic [WIDTH-1:0] alt_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pad_out[i] = use_alt[i] ? alt_out[i] : sw_out[i];
    assign pad_oe[i]  = use_alt[i] ? alt_oe[i]  : sw_oe[i];
  end

endmodule

// File: rtl/gpio_flags.sv
module gpio_flags #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] match_vec,
  output logic [WIDTH-1:0] flag_q
);

  function automatic logic [WIDTH-1:0] level_hit(input logic [WIDTH-1:0] pins,
                                                 input logic [WIDTH-1:0] lvl);
    return ~(pins ^ lvl);
  endfunction

  assign match_vec = level_hit(pin_sync, level);

  // a match in the same cycle overrides a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_mask) | match_vec;
    end
  end

endmodule

// File: rtl/gpio_lvlirq.sv
module gpio_lvlirq
  import gpio_lvlirq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_we,
  input  logic [NUM_PINS-1:0]   bus_wdata,
  output logic [NUM_PINS-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  input  logic [NUM_PINS-1:0]   alt_out,
  input  logic [NUM_PINS-1:0]   alt_oe,
  output logic [NUM_PINS-1:0]   alt_in,
  output logic                  irq,
  output logic                  nmi
);

  function automatic logic any_routed(input logic [NUM_PINS-1:0] flags,
                                      input logic [NUM_PINS-1:0] mask);
    return |(flags & mask);
  endfunction

  reg_sel_e            sel;
  logic [NUM_PINS-1:0] func_q, dir_q, data_q, level_q, route_q;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] match_vec;
  logic [NUM_PINS-1:0] clr_mask;
  logic [NUM_PINS-1:0] flag_q;
  logic                wr_func, wr_dir, wr_data, wr_level, wr_flag, wr_route;

  assign sel      = reg_sel_e'(bus_addr);
  assign wr_func  = bus_we && (sel == REG_FUNC);
  assign wr_dir   = bus_we && (sel == REG_DIR);
  assign wr_data  = bus_we && (sel == REG_DATA);
  assign wr_level = bus_we && (sel == REG_LEVEL);
  assign wr_flag  = bus_we && (sel == REG_FLAG);
  assign wr_route = bus_we && (sel == REG_ROUTE);
  assign clr_mask = wr_flag ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q  <= '0;
      dir_q   <= '0;
      data_q  <= '0;
      level_q <= '0;
      route_q <= '0;
    end else begin
      if (wr_func)  func_q  <= bus_wdata;
      if (wr_dir)   dir_q   <= bus_wdata;
      if (wr_data)  data_q  <= bus_wdata;
      if (wr_level) level_q <= bus_wdata;
      if (wr_route) route_q <= bus_wdata;
    end
  end

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_pinmux #(.WIDTH(NUM_PINS)) u_mux (
    .use_alt (func_q),
    .sw_out  (data_q),
    .sw_oe   (dir_q),
    .alt_out (alt_out),
    .alt_oe  (alt_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  gpio_flags #(.WIDTH(NUM_PINS)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_sync  (pin_sync),
    .level     (level_q),
    .clr_mask  (clr_mask),
    .match_vec (match_vec),
    .flag_q    (flag_q)
  );

  always_comb begin
    case (sel)
      REG_FUNC:  bus_rdata = func_q;
      REG_DIR:   bus_rdata = dir_q;
      REG_DATA:  bus_rdata = pin_sync;
      REG_LEVEL: bus_rdata = level_q;
      REG_FLAG:  bus_rdata = flag_q;
      REG_ROUTE: bus_rdata = route_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign alt_in = pin_sync;
  assign nmi    = any_routed(flag_q, route_q);
  assign irq    = any_routed(flag_q, ~route_q);

endmodule

// File: rtl/gpio_lvlirq_chk.sv
module gpio_lvlirq_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] flag_q,
  input logic [WIDTH-1:0] match_vec,
  input logic [WIDTH-1:0] clr_mask,
  input logic [WIDTH-1:0] pad_oe,
  input logic             irq,
  input logic             nmi
);

  // R1: outputs quiet while reset is held
  assert_reset_quiet_R1: assert property (@(negedge clk)
    !rst_n |-> (flag_q == '0 && pad_oe == '0 && !irq && !nmi));

  // R5: a match raises its flag one edge later
  assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(match_vec) & ~flag_q) == '0));

  // R6: an uncleared flag never drops
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag_q) & ~$past(clr_mask) & ~flag_q) == '0));

  // R7: a clear without a match empties the bit
  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(clr_mask) & ~$past(match_vec)) == '0));

  // R9: some interrupt line is up exactly when some flag is set
  assert_irq_cover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != '0) == (irq || nmi));

endmodule

bind gpio_lvlirq gpio_lvlirq_chk #(.WIDTH(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flag_q    (flag_q),
  .match_vec (match_vec),
  .clr_mask  (clr_mask),
  .pad_oe    (pad_oe),
  .irq       (irq),
  .nmi       (nmi)
);

// File: tb/gpio_lvlirq_tb.sv
module gpio_lvlirq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic [31:0] alt_out = '0, alt_oe = '0;
  logic [31:0] alt_in;
  logic        irq, nmi;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_lvlirq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe),
    .alt_in(alt_in), .irq(irq), .nmi(nmi)
  );

  // reference state built from the requirements
  logic [31:0] m_func, m_dir, m_data, m_lvl, m_flag, m_route, m_p1, m_p2;

  function automatic logic [31:0] ref_hits(input logic [31:0] p, input logic [31:0] l);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (p[i] == l[i]);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_func, m_dir, m_data, m_lvl, m_flag, m_route, m_p1, m_p2} <= '0;
    end else begin
      m_p1 <= pad_in;
      m_p2 <= m_p1;
      m_flag <= ref_hits(m_p2, m_lvl) |
                (m_flag & ~((bus_we && bus_addr == 3'd4) ? bus_wdata : 32'd0));
      if (bus_we) begin
        case (bus_addr)
          3'd0: m_func  <= bus_wdata;
          3'd1: m_dir   <= bus_wdata;
          3'd2: m_data  <= bus_wdata;
          3'd3: m_lvl   <= bus_wdata;
          3'd5: m_route <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] ref_read(input logic [2:0] a);
    case (a)
      3'd0: return m_func;
      3'd1: return m_dir;
      3'd2: return m_p2;
      3'd3: return m_lvl;
      3'd4: return m_flag;
      3'd5: return m_route;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] ref_pick(input logic [31:0] s, input logic [31:0] a,
                                           input logic [31:0] b);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = s[i] ? b[i] : a[i];
    return r;
  endfunction

  function automatic logic ref_any(input logic [31:0] f, input logic [31:0] m);
    for (int i = 0; i < 32; i++) if (f[i] && m[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic model_check();
    chk("R2 rdata", bus_rdata, ref_read(bus_addr));
    chk("R3 pad_out", pad_out, ref_pick(m_func, m_data, alt_out));
    chk("R3 pad_oe", pad_oe, ref_pick(m_func, m_dir, alt_oe));
    chk("R4 alt_in", alt_in, m_p2);
    chk("R9 nmi", {31'd0, nmi}, {31'd0, ref_any(m_flag, m_route)});
    chk("R9 irq", {31'd0, irq}, {31'd0, ref_any(m_flag, ~m_route)});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    pad_in = 32'h0000_FFFF;
    idle(3);
    // R1: reset state
    rd(3'd4, 32'd0, "R1 flags in reset");
    chk("R1 pad_oe in reset", pad_oe, 32'd0);
    chk("R1 irq/nmi in reset", {30'd0, irq, nmi}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    // synchroniser held zero during reset, level 0 matched every pin
    rd(3'd4, 32'hFFFF_FFFF, "R5 all matched after reset");
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, 32'hFFFF_0000, "R8 set beats clear");
    wr(3'd3, 32'hFFFF_0000);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, 32'h0000_0000, "R7 clear all");
    pad_in = 32'h00FF_FFFF;
    idle(4);
    rd(3'd4, 32'h00FF_0000, "R5 new match");
    pad_in = 32'h0000_FFFF;
    idle(4);
    rd(3'd4, 32'h00FF_0000, "R6 sticky after mismatch");
    wr(3'd4, 32'h000F_0000);
    rd(3'd4, 32'h00F0_0000, "R7 partial clear");
    chk("R9 irq only", {30'd0, irq, nmi}, 32'd2);
    wr(3'd5, 32'h0080_0000);
    chk("R9 both lines", {30'd0, irq, nmi}, 32'd3);
    wr(3'd5, 32'h00F0_0000);
    chk("R9 nmi only", {30'd0, irq, nmi}, 32'd1);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, 32'd0, "R2 unused offset reads zero");
    rd(3'd5, 32'h00F0_0000, "R2 route unchanged by offset 6");
    rd(3'd3, 32'hFFFF_0000, "R2 level readback");
    wr(3'd1, 32'h0000_00FF);
    wr(3'd2, 32'h0000_00A5);
    chk("R3 gpio out", pad_out & 32'hFF, 32'hA5);
    chk("R3 gpio oe", pad_oe, 32'h0000_00FF);
    alt_out = 32'h0000_0003; alt_oe = 32'd0;
    wr(3'd0, 32'h0000_000F);
    chk("R3 alt out", pad_out & 32'hFF, 32'hA3);
    chk("R3 alt oe", pad_oe, 32'h0000_00F0);
    rd(3'd2, 32'h0000_FFFF, "R4 data reads pins");
    pad_in = 32'h1234_5678;
    @(negedge clk);
    rd(3'd2, 32'h0000_FFFF, "R4 one edge not enough");
    @(negedge clk);
    rd(3'd2, 32'h1234_5678, "R4 visible after two edges");
    chk("R4 alt_in", alt_in, 32'h1234_5678);

    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      model_check();
      pad_in    = $urandom();
      alt_out   = $urandom();
      alt_oe    = $urandom();
      bus_we    = ($urandom() % 2) == 0;
      bus_addr  = 3'($urandom() % 8);
      bus_wdata = (($urandom() % 4) == 0) ? 32'hFFFF_FFFF : $urandom();
    end
    @(negedge clk);
    bus_we = 1'b0;
    model_check();
    done = 1;
    finish_run();
  end

endmodule